// File: doc/BRIEF.md
# Region Attribute Table

This block keeps two attribute flags, cacheable and prefetchable, for every fixed 16 MB region of a 32-bit logical address space. That gives 256 regions, and each one is selected by the top eight address bits. A configuration port reads and writes one 32-bit attribute word per region. A lookup port takes a full logical address and returns the two flags of its region in the same cycle, so a cache or prefetch unit can consult it on every request.

Only two bits of each word are implemented: bit 0 (cacheable) and bit 3 (prefetchable). Every other bit is discarded on write and reads as zero. Regions 0 to 15 describe core-internal memory. Their words are fixed at zero and cannot be changed. A write aimed at one of them is dropped and reported by a single-cycle error pulse.

Top module: `region_attr_table`

## Requirements
- R1: After reset every region word reads as zero on `cfg_rdata`, and the lookup returns both flags low for every address.
- R2: A write with `cfg_wr` high to a region index of 16 or more stores bit 0 (cacheable) and bit 3 (prefetchable) of `cfg_wdata` at the clock edge. The new value is visible on `cfg_rdata` from the next cycle.
- R3: The bits of `cfg_rdata` other than 0 and 3 are always zero, even after a write that sets them.
- R4: A write to a region index from 0 to 15 leaves that word unchanged, so it still reads as zero.
- R5: A write to index 0 to 15 raises `cfg_werr` for exactly the one cycle that follows the write edge. A write to index 16 or above leaves `cfg_werr` low.
- R6: The lookup region index is `lk_addr[31:24]`. `lk_cacheable` equals bit 0 and `lk_prefetchable` equals bit 3 of that region's word, combinationally.
- R7: Bits 23:0 of `lk_addr` have no effect on the lookup result.
- R8: A write changes only the addressed region. All other regions keep their values.
- R9: A later write replaces a stored word, so flags that were set can be cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 8 | Region index for configuration read and write |
| cfg_wdata | input | 32 | Attribute word to write |
| cfg_rdata | output | 32 | Attribute word of region `cfg_idx` (combinational) |
| cfg_werr | output | 1 | One-cycle pulse after a write to a read-only region |
| lk_addr | input | 32 | Logical address to classify |
| lk_cacheable | output | 1 | Cacheable flag of the region holding `lk_addr` |
| lk_prefetchable | output | 1 | Prefetchable flag of the region holding `lk_addr` |

## Verification
A corrupted stored word, for example a stuck flag or a write that lands on the wrong index, shows up on `cfg_rdata` as soon as that index is selected, one cycle after the write edge. The same fault reaches the lookup outputs in the same cycle for any address in the affected region. A faulty read-only guard shows up in two ways: a read-only word turns nonzero when read back, and the `cfg_werr` pulse is missing or mistimed in the cycle right after the write. Any address bit that leaks into the region decode makes two addresses in one region return different flags.

// File: rtl/region_attr_pkg.sv
package region_attr_pkg;

    // Bit positions inside the 32-bit attribute word; software depends on them.
    localparam int unsigned CACHE_POS = 0;
    localparam int unsigned PREF_POS  = 3;

    // The only state kept per region.
    typedef struct packed {
        logic pref;
        logic cache;
    } attr_t;

endpackage

// File: rtl/region_attr_store.sv
module region_attr_store
    import region_attr_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned RO_REGIONS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  attr_t            wattr,
    input  logic [IDX_W-1:0] ridx_cfg,
    input  logic [IDX_W-1:0] ridx_lk,
    output attr_t            rattr_cfg,
    output attr_t            rattr_lk
);
    localparam int unsigned NUM_REGIONS = 1 << IDX_W;
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_REGIONS);

    typedef struct packed {
        attr_t [NUM_REGIONS-1:0] attrs;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && (widx >= RO_LIMIT)) begin
            st_d.attrs[widx] = wattr;
        end
        // Read-only regions are constant zero.
        for (int i = 0; i < int'(RO_REGIONS); i++) begin
            st_d.attrs[i] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rattr_cfg = st_q.attrs[ridx_cfg];
    assign rattr_lk  = st_q.attrs[ridx_lk];

    // A write to a writable region lands in exactly that slot.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (widx >= RO_LIMIT)) |=> (st_q.attrs[$past(widx)] == $past(wattr)));

    // Region 0 never holds a nonzero value.
    assert_ro_unchanged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (widx == '0)) |=> (st_q.attrs[0] == '0));

endmodule

// File: rtl/region_attr_cfg.sv
module region_attr_cfg
    import region_attr_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RO_REGIONS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  attr_t             rattr,
    output logic              we,
    output attr_t             wattr,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_werr
);
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_REGIONS);
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << CACHE_POS) | (DATA_W'(1) << PREF_POS);

    typedef struct packed {
        logic werr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.werr = cfg_wr && (cfg_idx < RO_LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we          = cfg_wr;
    assign wattr.cache = cfg_wdata[CACHE_POS];
    assign wattr.pref  = cfg_wdata[PREF_POS];
    assign cfg_werr    = st_q.werr;

    always_comb begin
        cfg_rdata            = '0;
        cfg_rdata[CACHE_POS] = rattr.cache;
        cfg_rdata[PREF_POS]  = rattr.pref;
    end

    // Error pulse follows a protected write by one cycle.
    assert_werr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_idx < RO_LIMIT)) |=> cfg_werr);

    // No error pulse without a protected write before it.
    assert_werr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && (cfg_idx < RO_LIMIT)) |=> !cfg_werr);

    // Reserved bits never read back as one.
    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~IMPL_MASK) == '0);

endmodule

// File: rtl/region_attr_table.sv
module region_attr_table
    import region_attr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned RO_REGIONS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              cfg_werr,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_cacheable,
    output logic              lk_prefetchable
);
    localparam int unsigned IDX_LSB = ADDR_W - IDX_W;
    localparam logic [IDX_W-1:0] RO_LIMIT = IDX_W'(RO_REGIONS);

    logic             we;
    attr_t            wattr;
    attr_t            rattr_cfg;
    attr_t            rattr_lk;
    logic [IDX_W-1:0] lk_idx;

    assign lk_idx = lk_addr[ADDR_W-1:IDX_LSB];

    region_attr_cfg #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .RO_REGIONS(RO_REGIONS)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rattr(rattr_cfg), .we(we), .wattr(wattr),
        .cfg_rdata(cfg_rdata), .cfg_werr(cfg_werr)
    );

    region_attr_store #(
        .IDX_W(IDX_W), .RO_REGIONS(RO_REGIONS)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(cfg_idx), .wattr(wattr),
        .ridx_cfg(cfg_idx), .ridx_lk(lk_idx),
        .rattr_cfg(rattr_cfg), .rattr_lk(rattr_lk)
    );

    assign lk_cacheable    = rattr_lk.cache;
    assign lk_prefetchable = rattr_lk.pref;

    // Lookup into an internal-memory region reports no attributes.
    assert_lookup_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[ADDR_W-1:IDX_LSB] < RO_LIMIT) |-> (!lk_cacheable && !lk_prefetchable));

    // Lookup and configuration read agree when both select one region.
    assert_ports_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_addr[ADDR_W-1:IDX_LSB] == cfg_idx) |->
        ((lk_cacheable == cfg_rdata[CACHE_POS]) && (lk_prefetchable == cfg_rdata[PREF_POS])));

endmodule

// File: tb/test_region_attr_table.sv
module test_region_attr_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_werr;
    logic [31:0] lk_addr = '0;
    logic        lk_cacheable;
    logic        lk_prefetchable;

    always #10 clk = ~clk;   // 50 MHz

    region_attr_table i_region_attr_table (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_werr(cfg_werr),
        .lk_addr(lk_addr), .lk_cacheable(lk_cacheable),
        .lk_prefetchable(lk_prefetchable)
    );

    // kind: 0 = cfg_rdata, 1 = lookup {pref,cache}, 2 = cfg_werr
    typedef struct {
        int          kind;
        int          req;
        logic [31:0] exp;
    } item_t;

    item_t       sb_q[$];
    int          n_vec = 0;
    int          n_bad = 0;
    logic [31:0] model [256];
    bit          done = 0;

    // Expected word from the requirements: read-only regions stay zero,
    // only bits 0 and 3 survive.
    function automatic logic [31:0] exp_word(input int idx, input logic [31:0] d);
        if (idx < 16) return 32'h0;
        return d & 32'h0000_0009;
    endfunction

    // Monitor: compares shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0: act = cfg_rdata;
                1: act = {30'd0, lk_prefetchable, lk_cacheable};
                default: act = {31'd0, cfg_werr};
            endcase
            n_vec++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL R%0d kind %0d actual %h expected %h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic push(input int kind, input int req, input logic [31:0] exp);
        item_t it;
        it.kind = kind; it.req = req; it.exp = exp;
        sb_q.push_back(it);
    endtask

    // Write one word; next cycle checks the error pulse, the one after its end.
    task automatic do_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 8'(idx); cfg_wdata = d;
        if (idx >= 16) model[idx] = exp_word(idx, d);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
        push(2, 5, (idx < 16) ? 32'd1 : 32'd0);     // R5 pulse present/absent
        @(negedge clk);
        push(2, 5, 32'd0);                          // R5 pulse lasts one cycle
    endtask

    task automatic do_read(input int idx, input int req);
        @(negedge clk);
        cfg_idx = 8'(idx);
        push(0, req, model[idx]);
    endtask

    task automatic do_lookup(input logic [31:0] a, input int req);
        logic [31:0] w;
        @(negedge clk);
        lk_addr = a;
        w = model[a[31:24]];
        push(1, req, {30'd0, w[3], w[0]});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state on both ports
        do_read(0, 1); do_read(16, 1); do_read(255, 1);
        do_lookup(32'h2000_0000, 1);
        do_lookup(32'hFFFF_FFFF, 1);

        // R2, R3: all-ones write keeps only bits 0 and 3
        do_write(16, 32'hFFFF_FFFF);
        do_read(16, 2);
        do_read(16, 3);

        // R4, R5: protected regions ignore writes and pulse the error
        do_write(5, 32'h0000_0009);
        do_read(5, 4);
        do_write(15, 32'hFFFF_FFFF);
        do_read(15, 4);
        do_write(0, 32'h0000_0001);
        do_read(0, 4);
        do_lookup(32'h0F12_3456, 4);

        // R6, R7: flags by top byte, low bits irrelevant
        do_lookup(32'h10AB_CDEF, 6);
        do_lookup(32'h1000_0000, 7);
        do_lookup(32'h10FF_FFFF, 7);
        do_write(128, 32'h0000_0001);
        do_lookup(32'h80FF_FFFF, 6);
        do_write(255, 32'h0000_0008);
        do_lookup(32'hFF00_0000, 6);
        do_lookup(32'hFF80_0001, 7);

        // R8: neighbours untouched
        do_lookup(32'h1100_0000, 8);
        do_lookup(32'h7F00_0000, 8);
        do_read(17, 8); do_read(254, 8); do_read(16, 8);

        // R9: rewrite clears flags
        do_write(16, 32'h0000_0000);
        do_read(16, 9);
        do_lookup(32'h1012_3456, 9);

        // R2, R8: pattern sweep across writable regions, then read all back
        for (int i = 16; i < 256; i += 7) do_write(i, 32'(i * 32'h0101_0101));
        for (int i = 0; i < 256; i += 3) do_read(i, 8);
        for (int i = 0; i < 256; i += 5) do_lookup({8'(i), 24'h5A_5A5A}, 6);

        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R0 watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule